// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides the special result of a single-precision fused multiply-add, A*B+C, when at least one operand is a NaN or the product is infinity times zero. It runs alongside the arithmetic datapath. When it raises its hit flag, the datapath takes the block's result word and invalid flag in place of its own. The block itself does no rounding or arithmetic.

The choice between several NaN operands is data-driven. A seven-bit priority word lists the operands from most to least preferred, in three two-bit fields. One more bit in that word makes any signaling NaN outrank every quiet NaN. A separate byte governs the infinity-times-zero-plus-NaN case and can suppress the invalid flag for it. A default-NaN mode replaces every NaN result with a default NaN built from an eight-bit pattern. The block is purely combinational.

Top module: `fma_nan_sel`

## Requirements
- R1: `nan_hit` is 1 exactly when any operand is a NaN (exponent all ones, fraction nonzero) or one of A, B is an infinity and the other a zero. While `nan_hit` is 0, `nan_res`, `invalid` and `rule_err` are all 0.
- R2: The default NaN takes its sign from pattern bit 7 and has an all-ones exponent. Its fraction bits 22..16 are pattern bits 6..0, and fraction bits 15..0 each copy pattern bit 0.
- R3: With `dnan_mode` at 1 and `nan_hit` at 1, `nan_res` is the default NaN and `rule_err` is 0. The `invalid` flag still follows R8 and R10.
- R4: Priority-word bits 1:0 name the most preferred operand, bits 3:2 the next and bits 5:4 the least, with index 0 for A, 1 for B and 2 for C. With bit 6 clear, the first NaN operand in that order is propagated, whether it is quiet or signaling.
- R5: With priority-word bit 6 set and at least one signaling NaN present, the first signaling NaN in the field order is propagated, ahead of any quiet NaN.
- R6: A propagated operand NaN keeps its sign and all other bits, with fraction bit 22 forced to 1.
- R7: A priority word of 0 with `dnan_mode` at 0, when a NaN must be chosen by priority, sets `rule_err` and gives the default NaN.
- R8: Infinity times zero with a non-NaN C gives the default NaN and sets `invalid`.
- R9: Infinity times zero with a NaN C uses bits 1:0 of the infinity-zero byte. Code 1 gives C silenced. Code 2 gives the default NaN. Code 3 gives the default NaN if C is quiet and C silenced if C is signaling. Code 0 outside default-NaN mode sets `rule_err` and gives the default NaN.
- R10: `invalid` is 1 whenever any operand is a signaling NaN. Bit 7 of the infinity-zero byte clears `invalid` for infinity times zero plus a quiet-NaN C, and for no other case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Multiplicand A |
| op_b | input | 32 | Multiplier B |
| op_c | input | 32 | Addend C |
| prio_rule | input | 7 | Operand priority fields and signaling-first bit |
| izn_rule | input | 8 | Infinity-times-zero result code and invalid suppression |
| dnan_mode | input | 1 | Replace every NaN result with the default NaN |
| dnan_pat | input | 8 | Default NaN sign and top fraction bits |
| nan_res | output | 32 | Selected NaN result |
| nan_hit | output | 1 | Special result applies to this operation |
| invalid | output | 1 | Invalid-operation flag |
| rule_err | output | 1 | A needed rule was left unset |

## Verification
The assertions assume that every input is a known 0/1 value whenever they are evaluated. They also assume that any nonzero priority word names each of A, B and C exactly once. A repeated or out-of-range index would leave the order undefined, and the design then falls back to the default NaN. The stimulus uses only permutation words (0x24, 0x06, 0x09 and their signaling-first forms) or a word of 0. It changes inputs only on clock edges and reads outputs half a period later.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

   // operand slot numbering used by the priority fields
   localparam int unsigned N_OPS   = 3;
   localparam int unsigned IDX_W   = 2;
   localparam int unsigned RULE_W  = N_OPS * IDX_W + 1;
   localparam int unsigned SFIRST  = RULE_W - 1;
   localparam int unsigned PAT_W   = 8;

   // infinity-times-zero result codes (low two bits of the byte)
   typedef enum logic [1:0] {
      IZ_UNSET   = 2'd0,
      IZ_KEEP    = 2'd1,
      IZ_DEFAULT = 2'd2,
      IZ_DFLT_Q  = 2'd3
   } iz_code_e;

   typedef struct packed {
      logic nan;
      logic snan;
      logic inf;
      logic zero;
   } opnd_cls_t;

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
   import fma_nan_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] val,
   output opnd_cls_t    cls
);
   logic exp_ones, exp_none, frac_any, quiet_bit;

   assign exp_ones  = &val[FRAC_W +: EXP_W];
   assign exp_none  = ~|val[FRAC_W +: EXP_W];
   assign frac_any  = |val[FRAC_W-1:0];
   assign quiet_bit = val[FRAC_W-1];

   assign cls.nan  = exp_ones & frac_any;
   assign cls.snan = exp_ones & frac_any & ~quiet_bit;
   assign cls.inf  = exp_ones & ~frac_any;
   assign cls.zero = exp_none & ~frac_any;
endmodule

// File: rtl/fnan_dflt_gen.sv
module fnan_dflt_gen
   import fma_nan_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned W     = 1 + EXP_W + FRAC_W,
   localparam int unsigned TOP_W = PAT_W - 1
) (
   input  logic [PAT_W-1:0] pat,
   output logic [W-1:0]     dflt
);
   logic [FRAC_W-1:0] frac;

   generate
      if (FRAC_W > TOP_W) begin : g_fill
         assign frac = {pat[TOP_W-1:0], {(FRAC_W-TOP_W){pat[0]}}};
      end else begin : g_exact
         assign frac = pat[TOP_W-1:0];
      end
   endgenerate

   assign dflt = {pat[PAT_W-1], {EXP_W{1'b1}}, frac};
endmodule

// File: rtl/fnan_prio_pick.sv
module fnan_prio_pick
   import fma_nan_pkg::*;
(
   input  logic [N_OPS-1:0]  nan_v,
   input  logic [N_OPS-1:0]  snan_v,
   input  logic [RULE_W-1:0] rule,
   output logic              found,
   output logic [IDX_W-1:0]  sel
);
   logic [N_OPS-1:0] cand;

   assign cand = (rule[SFIRST] && (|snan_v)) ? snan_v : nan_v;

   // walk slots from least to most preferred so the earliest slot wins
   always_comb begin
      logic [IDX_W-1:0] idx;
      found = 1'b0;
      sel   = '0;
      for (int k = N_OPS - 1; k >= 0; k--) begin
         idx = rule[k*IDX_W +: IDX_W];
         if ((32'(idx) < N_OPS) && cand[idx]) begin
            found = 1'b1;
            sel   = idx;
         end
      end
   end
endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
   import fma_nan_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0]      op_a,
   input  logic [W-1:0]      op_b,
   input  logic [W-1:0]      op_c,
   input  logic [RULE_W-1:0] prio_rule,
   input  logic [PAT_W-1:0]  izn_rule,
   input  logic              dnan_mode,
   input  logic [PAT_W-1:0]  dnan_pat,
   output logic [W-1:0]      nan_res,
   output logic              nan_hit,
   output logic              invalid,
   output logic              rule_err
);
   localparam logic [W-1:0] QUIET_MASK = W'(1) << (FRAC_W - 1);

   initial begin
      if (FRAC_W < PAT_W - 1)
         $error("fma_nan_sel: FRAC_W must hold the pattern bits");
      if (EXP_W < 2)
         $error("fma_nan_sel: EXP_W too small");
   end

   logic [W-1:0]     ops [N_OPS];
   opnd_cls_t        cls [N_OPS];
   logic [N_OPS-1:0] nan_v, snan_v;

   assign ops[0] = op_a;
   assign ops[1] = op_b;
   assign ops[2] = op_c;

   generate
      for (genvar g = 0; g < N_OPS; g++) begin : g_cls
         fnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val (ops[g]),
            .cls (cls[g])
         );
         assign nan_v[g]  = cls[g].nan;
         assign snan_v[g] = cls[g].snan;
      end
   endgenerate

   logic [W-1:0] dflt;
   fnan_dflt_gen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dflt (
      .pat  (dnan_pat),
      .dflt (dflt)
   );

   logic             pick_ok;
   logic [IDX_W-1:0] pick_sel;
   fnan_prio_pick u_pick (
      .nan_v  (nan_v),
      .snan_v (snan_v),
      .rule   (prio_rule),
      .found  (pick_ok),
      .sel    (pick_sel)
   );

   logic     inf_zero, any_nan, any_snan, c_quiet_nan;
   iz_code_e iz_code;

   assign inf_zero    = (cls[0].inf & cls[1].zero) | (cls[0].zero & cls[1].inf);
   assign any_nan     = |nan_v;
   assign any_snan    = |snan_v;
   assign c_quiet_nan = cls[2].nan & ~cls[2].snan;
   assign iz_code     = iz_code_e'(izn_rule[1:0]);

   always_comb begin
      nan_res  = '0;
      nan_hit  = any_nan | inf_zero;
      rule_err = 1'b0;
      invalid  = any_snan |
                 (inf_zero & ~(c_quiet_nan & izn_rule[PAT_W-1]));
      if (!nan_hit) begin
         invalid = 1'b0;
      end else if (dnan_mode) begin
         nan_res = dflt;
      end else if (inf_zero) begin
         if (!cls[2].nan) begin
            nan_res = dflt;
         end else begin
            unique case (iz_code)
               IZ_KEEP:    nan_res = op_c | QUIET_MASK;
               IZ_DEFAULT: nan_res = dflt;
               IZ_DFLT_Q:  nan_res = cls[2].snan ? (op_c | QUIET_MASK) : dflt;
               default: begin
                  nan_res  = dflt;
                  rule_err = 1'b1;
               end
            endcase
         end
      end else if (prio_rule == '0) begin
         nan_res  = dflt;
         rule_err = 1'b1;
      end else if (pick_ok) begin
         nan_res = ops[pick_sel] | QUIET_MASK;
      end else begin
         nan_res = dflt;
      end
   end
endmodule

// File: rtl/fma_nan_sel_chk.sv
module fma_nan_sel_chk
   import fma_nan_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
   input logic [W-1:0]      op_a,
   input logic [W-1:0]      op_b,
   input logic [W-1:0]      op_c,
   input logic [RULE_W-1:0] prio_rule,
   input logic [PAT_W-1:0]  izn_rule,
   input logic              dnan_mode,
   input logic [PAT_W-1:0]  dnan_pat,
   input logic [W-1:0]      nan_res,
   input logic              nan_hit,
   input logic              invalid,
   input logic              rule_err
);
   function automatic logic is_nan(input logic [W-1:0] v);
      return (&v[FRAC_W +: EXP_W]) && (|v[FRAC_W-1:0]);
   endfunction
   function automatic logic is_snan(input logic [W-1:0] v);
      return is_nan(v) && !v[FRAC_W-1];
   endfunction
   function automatic logic is_inf(input logic [W-1:0] v);
      return (&v[FRAC_W +: EXP_W]) && !(|v[FRAC_W-1:0]);
   endfunction
   function automatic logic is_zero(input logic [W-1:0] v);
      return v[W-2:0] == '0;
   endfunction

   logic         iz, anyn, anys;
   logic [W-1:0] want_dflt;

   assign iz   = (is_inf(op_a) && is_zero(op_b)) || (is_zero(op_a) && is_inf(op_b));
   assign anyn = is_nan(op_a) || is_nan(op_b) || is_nan(op_c);
   assign anys = is_snan(op_a) || is_snan(op_b) || is_snan(op_c);
   assign want_dflt = {dnan_pat[7], {EXP_W{1'b1}}, dnan_pat[6:0],
                       {(FRAC_W-7){dnan_pat[0]}}};

   always_comb begin
      assert_hit_match_R1: assert (nan_hit == (anyn || iz))
         else $error("nan_hit mismatch");
      if (!nan_hit)
         assert_idle_zero_R1: assert (nan_res == '0 && !invalid && !rule_err)
            else $error("outputs active without hit");
      if (nan_hit && dnan_mode)
         assert_dmode_dflt_R3: assert (nan_res == want_dflt && !rule_err)
            else $error("default-NaN mode not honoured");
      if (anys)
         assert_snan_invalid_R10: assert (invalid)
            else $error("signaling NaN without invalid");
      if (nan_hit && nan_res != want_dflt)
         assert_quiet_result_R6: assert (is_nan(nan_res) && nan_res[FRAC_W-1])
            else $error("propagated result not a quiet NaN");
      if (rule_err)
         assert_err_context_R7: assert (!dnan_mode && nan_hit)
            else $error("rule error out of context");
   end
endmodule

bind fma_nan_sel fma_nan_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .op_a      (op_a),
   .op_b      (op_b),
   .op_c      (op_c),
   .prio_rule (prio_rule),
   .izn_rule  (izn_rule),
   .dnan_mode (dnan_mode),
   .dnan_pat  (dnan_pat),
   .nan_res   (nan_res),
   .nan_hit   (nan_hit),
   .invalid   (invalid),
   .rule_err  (rule_err)
);

// File: tb/fma_nan_sel_bench.sv
module fma_nan_sel_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] op_a, op_b, op_c, nan_res;
   logic [6:0]  prio_rule;
   logic [7:0]  izn_rule, dnan_pat;
   logic        dnan_mode, nan_hit, invalid, rule_err;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   fma_nan_sel u_fma_nan_sel (
      .op_a(op_a), .op_b(op_b), .op_c(op_c), .prio_rule(prio_rule),
      .izn_rule(izn_rule), .dnan_mode(dnan_mode), .dnan_pat(dnan_pat),
      .nan_res(nan_res), .nan_hit(nan_hit), .invalid(invalid), .rule_err(rule_err)
   );

   localparam logic [31:0] QA = 32'h7fc0_0001, QB = 32'h7fc0_0002, QC = 32'h7fc0_0003;
   localparam logic [31:0] SA = 32'h7f80_0011, SB = 32'hff80_0022, SC = 32'h7f80_0033;
   localparam logic [31:0] ONE = 32'h3f80_0000, TWO = 32'h4000_0000;
   localparam logic [31:0] INF = 32'h7f80_0000, NINF = 32'hff80_0000, ZERO = 32'h0;
   localparam logic [31:0] D40 = 32'h7fc0_0000, DC1 = 32'hffc1_ffff, D01 = 32'h7f81_ffff;

   typedef struct packed {
      logic [31:0] a, b, c;
      logic [6:0]  rule;
      logic [7:0]  izn;
      logic        dm;
      logic [7:0]  pat;
      logic [31:0] res;
      logic        hit, inv, err;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t TBL [NV] = '{
      '{ONE, TWO, ONE, 7'h24, 8'h00, 1'b0, 8'h40, 32'h0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 no special case
      '{QA,  QB,  QC,  7'h24, 8'h00, 1'b0, 8'h40, QA,    1'b1, 1'b0, 1'b0, 4'd4},  // R4 order A,B,C
      '{QA,  QB,  QC,  7'h06, 8'h00, 1'b0, 8'h40, QC,    1'b1, 1'b0, 1'b0, 4'd4},  // R4 order C,B,A
      '{QA,  SB,  ONE, 7'h24, 8'h00, 1'b0, 8'h40, QA,    1'b1, 1'b1, 1'b0, 4'd4},  // R4 kind ignored
      '{QA,  SB,  ONE, 7'h64, 8'h00, 1'b0, 8'h40, 32'hffc0_0022, 1'b1, 1'b1, 1'b0, 4'd5}, // R5
      '{ONE, QB,  SC,  7'h09, 8'h00, 1'b0, 8'h40, QB,    1'b1, 1'b1, 1'b0, 4'd4},  // R4 order B,C,A
      '{ONE, QB,  SC,  7'h46, 8'h00, 1'b0, 8'h40, 32'h7fc0_0033, 1'b1, 1'b1, 1'b0, 4'd5}, // R5
      '{SA,  ONE, ONE, 7'h24, 8'h00, 1'b0, 8'h40, 32'h7fc0_0011, 1'b1, 1'b1, 1'b0, 4'd6}, // R6 silence
      '{QA,  QB,  QC,  7'h00, 8'h00, 1'b0, 8'h40, D40,   1'b1, 1'b0, 1'b1, 4'd7},  // R7 unset rule
      '{QA,  QB,  QC,  7'h00, 8'h00, 1'b1, 8'hc1, DC1,   1'b1, 1'b0, 1'b0, 4'd3},  // R3 + R2 pattern
      '{SA,  ONE, ONE, 7'h24, 8'h00, 1'b1, 8'h01, D01,   1'b1, 1'b1, 1'b0, 4'd2},  // R2 low-bit fill
      '{INF, ZERO, ONE, 7'h24, 8'h00, 1'b0, 8'h40, D40,  1'b1, 1'b1, 1'b0, 4'd8},  // R8
      '{ZERO, NINF, TWO, 7'h24, 8'h00, 1'b0, 8'hc1, DC1, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 swapped
      '{INF, ZERO, QC, 7'h24, 8'h01, 1'b0, 8'h40, QC,    1'b1, 1'b1, 1'b0, 4'd9},  // R9 code 1
      '{INF, ZERO, QC, 7'h24, 8'h02, 1'b0, 8'h40, D40,   1'b1, 1'b1, 1'b0, 4'd9},  // R9 code 2
      '{INF, ZERO, QC, 7'h24, 8'h03, 1'b0, 8'h40, D40,   1'b1, 1'b1, 1'b0, 4'd9},  // R9 code 3 quiet
      '{INF, ZERO, SC, 7'h24, 8'h03, 1'b0, 8'h40, 32'h7fc0_0033, 1'b1, 1'b1, 1'b0, 4'd9}, // R9 code 3 sig
      '{INF, ZERO, QC, 7'h24, 8'h81, 1'b0, 8'h40, QC,    1'b1, 1'b0, 1'b0, 4'd10}, // R10 suppress
      '{INF, ZERO, SC, 7'h24, 8'h81, 1'b0, 8'h40, 32'h7fc0_0033, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 sNaN
      '{INF, ZERO, QC, 7'h24, 8'h00, 1'b0, 8'h40, D40,   1'b1, 1'b1, 1'b1, 4'd9},  // R9 code 0
      '{INF, ONE,  QC, 7'h24, 8'h00, 1'b0, 8'h40, QC,    1'b1, 1'b0, 1'b0, 4'd1},  // R1 inf*finite
      '{INF, ZERO, QC, 7'h24, 8'h82, 1'b0, 8'h40, D40,   1'b1, 1'b0, 1'b0, 4'd10}, // R10 with code 2
      '{INF, INF,  ONE, 7'h24, 8'h00, 1'b0, 8'h40, 32'h0, 1'b0, 1'b0, 1'b0, 4'd1}, // R1 inf*inf
      '{ZERO, ZERO, QC, 7'h24, 8'h00, 1'b0, 8'h40, QC,   1'b1, 1'b0, 1'b0, 4'd1}   // R1 zero*zero
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(posedge clk);
      op_a = v.a; op_b = v.b; op_c = v.c; prio_rule = v.rule;
      izn_rule = v.izn; dnan_mode = v.dm; dnan_pat = v.pat;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      op_a = '0; op_b = '0; op_c = '0; prio_rule = '0;
      izn_rule = '0; dnan_mode = 1'b0; dnan_pat = 8'h40;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: idle state with zero operands during reset
      check("R1 reset res", nan_res, 32'h0);
      check("R1 reset flags", {29'h0, nan_hit, invalid, rule_err}, 32'h0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         apply(TBL[i]);
         check($sformatf("R%0d row %0d res", TBL[i].rq, i), nan_res, TBL[i].res);
         check($sformatf("R%0d row %0d flags", TBL[i].rq, i),
               {29'h0, nan_hit, invalid, rule_err},
               {29'h0, TBL[i].hit, TBL[i].inv, TBL[i].err});
      end

      // R3 with R10: suppression bit still clears invalid in default-NaN mode
      apply('{INF, ZERO, QC, 7'h24, 8'h81, 1'b1, 8'h40, 32'h0, 1'b0, 1'b0, 1'b0, 4'd3});
      check("R3 dmode inf-zero res", nan_res, D40);
      check("R10 dmode suppressed invalid", {31'h0, invalid}, 32'h0);

      // R3: unset infinity-zero code gives no rule error in default-NaN mode
      apply('{INF, ZERO, QC, 7'h24, 8'h00, 1'b1, 8'hc1, 32'h0, 1'b0, 1'b0, 1'b0, 4'd3});
      check("R3 dmode no rule_err", {31'h0, rule_err}, 32'h0);
      check("R2 dmode pattern", nan_res, DC1);

      // R6: negative sNaN keeps sign and payload when propagated from C
      apply('{ONE, ONE, 32'hff80_5a5a, 7'h24, 8'h00, 1'b0, 8'h40, 32'h0, 1'b0, 1'b0, 1'b0, 4'd6});
      check("R6 negative payload", nan_res, 32'hffc0_5a5a);

      // R5: signaling-first with all quiet falls back to field order
      apply('{QA, QB, QC, 7'h46, 8'h00, 1'b0, 8'h40, 32'h0, 1'b0, 1'b0, 1'b0, 4'd5});
      check("R5 all quiet uses order", nan_res, QC);

      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      finish_run();
   end
endmodule